// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block sits behind three compare channels of a motor-control timer. Each channel's raw PWM waveform becomes two complementary drive signals: a high-side request that follows the waveform and a low-side request that follows its inverse. After every transition of the raw waveform, the side that is turning off drops at once. The side that is turning on is held back for a programmable dead interval. This keeps the two switches of a half-bridge from conducting together.

The dead interval is one 8-bit value shared by all three channels. Each channel counts that value on its own counter. The counter advances on a clock tick divided by 1, 2, 4, 8, 16 or 32. Each channel can skip dead-time insertion on its own.

A final stage maps each of the six requests onto its pin through a 2-bit action code. The codes come from a double-buffered action register. A write fills the shadow copy, and the live copy takes the shadow only on a reload strobe, normally a timer underflow.

Top module: `pwm_deadband_gen`

## Requirements
- R1: Synchronous active-low reset. While reset is held and on the first sample after release, all six outputs are 0, and both copies of the action register are all zero (every output forced low).
- R2: On a rising raw edge of a channel with insertion enabled and dead value D > 0, the low-side output (pin 2j+1 for channel j) turns off two clock edges after the raw change is sampled. The high-side output (pin 2j) turns on exactly D*N cycles later, where N is the prescale divide.
- R3: A falling raw edge is handled the mirror way: the high side turns off at once and the low side turns on D*N cycles later.
- R4: With a dead value of 0, the pair is a plain complement of the raw waveform, and both pins change in the same cycle.
- R5: With a channel's enable bit at 0, that channel's pair is a plain complement whatever the dead value is, while the other channels keep their dead time.
- R6: The prescale select maps 0,1,2,3,4,5 to a tick every 1,2,4,8,16,32 cycles; values 6 and 7 also give 32. The prescale phase restarts on every raw edge, so the dead interval is exactly D*N cycles.
- R7: A write strobe loads the 12-bit shadow copy only. The outputs keep using the old live codes until a reload strobe copies the shadow into the live copy. The new codes take effect on the edge after the reload.
- R8: The action code for pin i sits in bits [2i+1:2i]: 00 forces the pin low, 01 drives the inverse of its request, 10 drives the request, and 11 forces the pin high.
- R9: A raw pulse shorter than D*N cycles never turns on the side it would have enabled.
- R10: When a write and a reload occur in the same cycle, the live copy takes the previous shadow contents and the shadow takes the new data.
- R11: The high-side and low-side requests of a channel are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_raw | input | 3 | Raw PWM from the three compare channels |
| dead_val | input | 8 | Shared dead interval in prescaled ticks |
| presc_sel | input | 3 | Tick prescale select |
| db_en | input | 3 | Per-channel dead-time insertion enable |
| act_wr | input | 1 | Shadow action register write strobe |
| act_wdata | input | 12 | Shadow action data, 2 bits per pin |
| act_reload | input | 1 | Shadow-to-live copy strobe |
| pwm_out | output | 6 | Gated outputs; pin 2j high side, 2j+1 low side of channel j |

## Verification
The action-register write and the reload strobe can land in the same cycle. The bench raises both strobes on one clock with different data in the shadow and in the write. It then checks that the pins reflect the old shadow contents and that a later lone reload brings in the new data. Raw edges that arrive while an action reload takes effect are covered by the per-cycle behavioural model, which applies the live codes of the previous cycle to the requests.

// File: rtl/dbg_pkg.sv
// Shared constants, action codes and the prescale decode for the
// dead-time inserter. Assumes a prescale counter of PS_W bits, so the
// largest divide is 2**PS_W.
package dbg_pkg;

    localparam int PS_W   = 5;
    localparam int PSEL_W = 3;

    typedef enum logic [1:0] {
        ACT_FORCE_LO  = 2'b00,
        ACT_ACTIVE_LO = 2'b01,
        ACT_ACTIVE_HI = 2'b10,
        ACT_FORCE_HI  = 2'b11
    } act_code_e;

    // Mask of low counter bits that must all be one for a tick.
    function automatic logic [PS_W-1:0] presc_mask(input logic [PSEL_W-1:0] sel);
        logic [PS_W-1:0] m;
        m = '0;
        for (int b = 0; b < PS_W; b++) begin
            if (int'(sel) > b) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/db_channel.sv
// One dead-time channel. Turns one raw PWM line into a high-side and a
// low-side request. The side that is switching on waits until a local
// counter, advanced by prescaled ticks, reaches the shared dead value.
// Assumes dead_val and presc_sel are quasi-static relative to edges.
module db_channel
    import dbg_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_in,
    input  logic [DB_W-1:0]   dead_val,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic              en,
    output logic              hi_req,
    output logic              lo_req
);

    logic             raw_q;
    logic [DB_W-1:0]  cnt_q;
    logic [PS_W-1:0]  div_q;
    logic [PS_W-1:0]  mask;
    logic             edge_seen;
    logic             tick;
    logic             done;

    assign mask      = presc_mask(presc_sel);
    assign edge_seen = (raw_in != raw_q);
    assign tick      = ((div_q & mask) == mask);
    assign done      = !en || (cnt_q >= dead_val);

    // Hold the last sampled raw level.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= raw_in;
    end

    // Prescale counter, phase restarted on every raw edge.
    always_ff @(posedge clk) begin
        if (!rst_n || edge_seen) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    // Dead-time counter, cleared on an edge and saturating at dead_val.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (edge_seen)                  cnt_q <= '0;
        else if (tick && (cnt_q < dead_val)) cnt_q <= cnt_q + 1'b1;
    end

    assign hi_req = raw_q & done;
    assign lo_req = !raw_q & done;

    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_req && lo_req));

    // R2 R3
    edge_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && en && (dead_val != '0)) |=>
        (!en || (dead_val == '0) || (!hi_req && !lo_req)));

    // R4 R5
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || (dead_val == '0)) |-> ((hi_req == raw_q) && (lo_req == !raw_q)));

endmodule

// File: rtl/db_action_bank.sv
// Double-buffered action register. Writes land in the shadow copy; the
// live copy changes only on a reload strobe. Assumes a reload samples the
// shadow as it stood before a write in the same cycle.
module db_action_bank #(
    parameter int ACT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [ACT_W-1:0] wdata,
    input  logic             reload,
    output logic [ACT_W-1:0] live
);

    logic [ACT_W-1:0] shadow_q;
    logic [ACT_W-1:0] live_q;

    // Capture software data into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n)  shadow_q <= '0;
        else if (wr) shadow_q <= wdata;
    end

    // Transfer shadow to live on the reload strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      live_q <= '0;
        else if (reload) live_q <= shadow_q;
    end

    assign live = live_q;

    // R7
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(live_q));

    // R10
    reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (live_q == $past(shadow_q)));

endmodule

// File: rtl/db_out_drive.sv
// Output stage for one pin: applies a 2-bit action code to a request and
// registers the result. Assumes the code is already the live copy.
module db_out_drive
    import dbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    input  logic       req,
    output logic       dout
);

    logic nxt;

    // Decode the action code against the request.
    always_comb begin
        unique case (act_code_e'(code))
            ACT_FORCE_LO:  nxt = 1'b0;
            ACT_ACTIVE_LO: nxt = !req;
            ACT_ACTIVE_HI: nxt = req;
            default:       nxt = 1'b1;
        endcase
    end

    // Register the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= 1'b0;
        else        dout <= nxt;
    end

    // R8
    force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 2'b11) |=> dout);

    // R8
    force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 2'b00) |=> !dout);

endmodule

// File: rtl/pwm_deadband_gen.sv
// Top of the dead-time inserter: NUM_UNITS channels sharing one dead value
// and one prescale select, a double-buffered action register, and one
// output stage per pin. Pin 2j is the high side and pin 2j+1 the low side
// of channel j.
module pwm_deadband_gen
    import dbg_pkg::*;
#(
    parameter int NUM_UNITS = 3,
    parameter int DB_W      = 8,
    localparam int NUM_OUT  = 2 * NUM_UNITS,
    localparam int ACT_W    = 2 * NUM_OUT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] pwm_raw,
    input  logic [DB_W-1:0]      dead_val,
    input  logic [PSEL_W-1:0]    presc_sel,
    input  logic [NUM_UNITS-1:0] db_en,
    input  logic                 act_wr,
    input  logic [ACT_W-1:0]     act_wdata,
    input  logic                 act_reload,
    output logic [NUM_OUT-1:0]   pwm_out
);

    logic [NUM_OUT-1:0] req_vec;
    logic [ACT_W-1:0]   act_live;

    for (genvar j = 0; j < NUM_UNITS; j++) begin : g_chan
        db_channel #(.DB_W(DB_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (pwm_raw[j]),
            .dead_val  (dead_val),
            .presc_sel (presc_sel),
            .en        (db_en[j]),
            .hi_req    (req_vec[2*j]),
            .lo_req    (req_vec[2*j+1])
        );
    end

    db_action_bank #(.ACT_W(ACT_W)) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (act_wr),
        .wdata  (act_wdata),
        .reload (act_reload),
        .live   (act_live)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
        db_out_drive u_drv (
            .clk   (clk),
            .rst_n (rst_n),
            .code  (act_live[2*i+1:2*i]),
            .req   (req_vec[i]),
            .dout  (pwm_out[i])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));

endmodule

// File: tb/pwm_deadband_gen_bench.sv
module pwm_deadband_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  raw = '0;
    logic [7:0]  dead = '0;
    logic [2:0]  psel = '0;
    logic [2:0]  en = 3'b111;
    logic        wr = 1'b0;
    logic [11:0] wdata = '0;
    logic        reload = 1'b0;
    logic [5:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    int cycles = 0;

    always #4 clk = ~clk;

    pwm_deadband_gen u_pwm_deadband_gen (
        .clk(clk), .rst_n(rst_n), .pwm_raw(raw), .dead_val(dead),
        .presc_sel(psel), .db_en(en), .act_wr(wr), .act_wdata(wdata),
        .act_reload(reload), .pwm_out(pwm_out)
    );

    // Behavioural reference model.
    int          m_el [3];
    bit          m_raw [3];
    logic [11:0] m_shadow, m_live;
    logic [5:0]  m_out;

    function automatic int div_of(input logic [2:0] s);
        return (s >= 3'd5) ? 32 : (1 << s);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            foreach (m_el[j]) begin m_el[j] = 0; m_raw[j] = 1'b0; end
            m_shadow = '0; m_live = '0; m_out = '0;
        end else begin
            logic [5:0] rq;
            for (int j = 0; j < 3; j++) begin
                bit dn;
                dn = !en[j] || (m_el[j] >= int'(dead) * div_of(psel));
                rq[2*j]   = m_raw[j] && dn;
                rq[2*j+1] = !m_raw[j] && dn;
            end
            for (int i = 0; i < 6; i++) begin
                case (m_live[2*i +: 2])
                    2'b00: m_out[i] = 1'b0;
                    2'b01: m_out[i] = !rq[i];
                    2'b10: m_out[i] = rq[i];
                    default: m_out[i] = 1'b1;
                endcase
            end
            if (reload) m_live = m_shadow;
            if (wr) m_shadow = wdata;
            for (int j = 0; j < 3; j++) begin
                if (raw[j] != m_raw[j]) begin m_raw[j] = raw[j]; m_el[j] = 0; end
                else if (m_el[j] < 100000) m_el[j]++;
            end
        end
    end

    // Per-cycle comparison against the model (R2 R3 R11 and the rest).
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (pwm_out !== m_out) begin
                errors++;
                $display("FAIL R11 model: got %b expected %b at cycle %0d", pwm_out, m_out, cycles);
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Drive raw[j] to v and return the cycles between off-side drop and on-side rise.
    task automatic gap_meas(input int j, input logic v, output int gap);
        int off_i = -1;
        int on_i = -1;
        @(negedge clk);
        raw[j] = v;
        for (int n = 1; n <= 200; n++) begin
            @(negedge clk);
            if (off_i < 0 && pwm_out[2*j + (v ? 1 : 0)] == 1'b0) off_i = n;
            if (on_i < 0 && pwm_out[2*j + (v ? 0 : 1)] == 1'b1) on_i = n;
        end
        gap = (off_i < 0 || on_i < 0) ? -1 : on_i - off_i;
    endtask

    task automatic load_act(input logic [11:0] d);
        @(negedge clk); wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse_reload();
        @(negedge clk); reload = 1'b1;
        @(negedge clk); reload = 1'b0;
    endtask

    initial begin
        int g;
        wait_n(5);
        chk("R1 outputs in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after release", int'(pwm_out), 0);
        cmp_on = 1'b1;

        dead = 8'd3; psel = 3'd0; en = 3'b111;
        load_act(12'hAAA);
        wait_n(6);
        chk("R7 shadow only, pins still forced low", int'(pwm_out), 0);
        pulse_reload();
        wait_n(3);
        chk("R7 live after reload", int'(pwm_out), 6'h2A);

        gap_meas(0, 1'b1, g); chk("R2 rising dead gap D=3 N=1", g, 3);
        gap_meas(0, 1'b0, g); chk("R3 falling dead gap D=3 N=1", g, 3);

        psel = 3'd2; wait_n(10);
        gap_meas(1, 1'b1, g); chk("R6 gap D=3 N=4", g, 12);
        psel = 3'd7; wait_n(10);
        gap_meas(1, 1'b0, g); chk("R6 gap D=3 sel=7 N=32", g, 96);
        psel = 3'd0;

        dead = 8'd0; wait_n(5);
        gap_meas(2, 1'b1, g); chk("R4 zero dead rising", g, 0);
        gap_meas(2, 1'b0, g); chk("R4 zero dead falling", g, 0);

        cmp_on = 1'b0; dead = 8'd5; wait_n(400); cmp_on = 1'b1;
        en = 3'b110; wait_n(3);
        gap_meas(0, 1'b1, g); chk("R5 bypass unit0", g, 0);
        gap_meas(1, 1'b1, g); chk("R5 unit1 keeps dead time", g, 5);
        en = 3'b111; wait_n(5);
        gap_meas(0, 1'b0, g); chk("R3 falling D=5", g, 5);
        gap_meas(1, 1'b0, g);

        begin
            int hi_cnt = 0;
            @(negedge clk); raw[0] = 1'b1;
            wait_n(2); raw[0] = 1'b0;
            for (int n = 0; n < 30; n++) begin
                @(negedge clk);
                if (pwm_out[0]) hi_cnt++;
            end
            chk("R9 short pulse high-side count", hi_cnt, 0);
            chk("R9 low side restored", int'(pwm_out[1]), 1);
        end

        load_act(12'h87A);
        pulse_reload();
        wait_n(3);
        chk("R8 code decode pattern", int'(pwm_out), 6'h26);

        @(negedge clk); wr = 1'b1; wdata = 12'hAAA; reload = 1'b1;
        @(negedge clk); wr = 1'b0; reload = 1'b0;
        wait_n(3);
        chk("R10 same-cycle reload takes old shadow", int'(pwm_out), 6'h26);
        pulse_reload();
        wait_n(3);
        chk("R10 later reload takes new shadow", int'(pwm_out), 6'h2A);

        wait_n(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule